// File: doc/BRIEF.md
# Local Interrupt Controller Countdown Timer

This block is the countdown timer of a processor-local interrupt controller. Software loads a start value, picks a power-of-two clock divider and programs a timer vector entry. The entry holds an 8-bit vector, a mask flag and a one-shot/periodic select. The counter steps down once per prescaled tick. When an expiry is due, the block emits a single-cycle request that carries the programmed vector. The interrupt controller around it takes that request and handles arbitration and delivery.

A period lasts start value plus one prescaled ticks, counted from the clock edge that accepts the start-value write. A zero start value never expires. A masked entry suppresses the expiry itself, while the count keeps running underneath. Software can read the running count at any time through a small word-addressed register port.

Top module: `lvt_countdown_timer`

## Requirements
- R1: After reset the entry reads 0x0001_0000 (masked, one-shot, vector 0), the start value reads 0, the current count reads 0, the divide register reads 0, the divider is 1 and no request is raised.
- R2: Register words are: address 0 timer entry, address 1 start value, address 2 current count (read-only), address 3 divide setting. The divide code is {bit3,bit1,bit0}. Code 3'b111 divides by 1, and code c otherwise divides by 2^(c+1). Only bits 3, 1 and 0 read back.
- R3: In one-shot mode with start value S and divider N, a write to the start value accepted at edge E raises irq_pulse for exactly one cycle after edge E+(S+1)*N, and never again until the next start-value write.
- R4: In periodic mode, irq_pulse is raised after every edge E+m*(S+1)*N for m = 1, 2, and so on.
- R5: A start value of zero never raises irq_pulse, in either mode.
- R6: While entry bit 16 (mask) is set at the expiry tick, no request is raised. The count keeps running, and a masked one-shot expiry is lost.
- R7: irq_vector equals entry bits 7:0 during every cycle that irq_pulse is high.
- R8: Each write to the start value clears the divider phase and restarts the count from the new value.
- R9: After t prescaled ticks from the load, the current count reads S-t. In periodic mode it reads S-(t mod (S+1)). In one-shot mode it reads 0 once t >= S.
- R10: The entry keeps only bits 7:0 (vector), 16 (mask) and 17 (periodic). Other bits read 0. Writes to address 2 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_pulse | output | 1 | One-cycle expiry request |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
The assertions check four things on every cycle: that a request never lasts two cycles, that it only follows a prescaled tick, that it is blocked by the mask, and that it carries the entry vector. They also check that a periodic expiry reloads the count, a one-shot expiry leaves zero, and a start-value write restarts the count. The exact expiry cycle numbers for each divider, and the running-count values between expiries, come only from the bench's scenarios. So do the loss of a masked one-shot expiry and the register decode, which the bench compares against its own arithmetic model.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int REG_ADDR_W = 2;
  localparam logic [REG_ADDR_W-1:0] A_ENTRY = 2'd0;
  localparam logic [REG_ADDR_W-1:0] A_START = 2'd1;
  localparam logic [REG_ADDR_W-1:0] A_COUNT = 2'd2;
  localparam logic [REG_ADDR_W-1:0] A_DIV   = 2'd3;
  localparam int VEC_W     = 8;
  localparam int MASK_BIT  = 16;
  localparam int PER_BIT   = 17;
  localparam int SHIFT_W   = 3;

  typedef struct packed {
    logic             periodic;
    logic             mask;
    logic [VEC_W-1:0] vector;
  } lt_entry_t;

  // Divide code {b3,b1,b0}: 3'b111 -> shift 0, else shift = code + 1
  function automatic logic [SHIFT_W-1:0] div_to_shift(input logic [3:0] cfg);
    logic [2:0] code;
    code = {cfg[3], cfg[1], cfg[0]};
    if (code == 3'b111) return '0;
    return code + 3'd1;
  endfunction

  function automatic logic [31:0] entry_to_word(input lt_entry_t e);
    logic [31:0] w;
    w = '0;
    w[VEC_W-1:0] = e.vector;
    w[MASK_BIT]  = e.mask;
    w[PER_BIT]   = e.periodic;
    return w;
  endfunction
endpackage

// File: rtl/lt_regs.sv
module lt_regs
  import lt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [31:0]           reg_wdata,
  input  logic [CNT_W-1:0]      cur_count,
  output logic [31:0]           reg_rdata,
  output lt_entry_t             entry,
  output logic [CNT_W-1:0]      start_val,
  output logic [SHIFT_W-1:0]    shift,
  output logic                  load_evt
);
  logic [3:0] div_cfg;
  logic       unused_wbits;

  assign unused_wbits = ^{reg_wdata[31:18], reg_wdata[15:8], reg_wdata[2]};
  assign load_evt = reg_we && (reg_addr == A_START);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry     <= '{periodic: 1'b0, mask: 1'b1, vector: '0};
      start_val <= '0;
      div_cfg   <= '0;
      shift     <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_ENTRY: begin
          entry.vector   <= reg_wdata[VEC_W-1:0];
          entry.mask     <= reg_wdata[MASK_BIT];
          entry.periodic <= reg_wdata[PER_BIT];
        end
        A_START: start_val <= reg_wdata[CNT_W-1:0];
        A_DIV: begin
          div_cfg <= {reg_wdata[3], 1'b0, reg_wdata[1:0]};
          shift   <= div_to_shift(reg_wdata[3:0]);
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_ENTRY: reg_rdata = entry_to_word(entry);
      A_START: reg_rdata[CNT_W-1:0] = start_val;
      A_COUNT: reg_rdata[CNT_W-1:0] = cur_count;
      A_DIV:   reg_rdata[3:0] = div_cfg;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/lt_prescaler.sv
module lt_prescaler
  import lt_pkg::*;
#(
  parameter int SW = SHIFT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [SW-1:0] shift,
  output logic          tick
);
  localparam int PW = (1 << SW) - 1;
  logic [PW-1:0] phase;
  logic [PW-1:0] limit;

  assign limit = PW'((1 << shift) - 1);
  assign tick  = (phase >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) phase <= '0;
    else if (tick)       phase <= '0;
    else                 phase <= phase + 1'b1;
  end
endmodule

// File: rtl/lt_counter.sv
module lt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] start_val,
  input  logic             tick,
  input  logic             periodic,
  input  logic             mask,
  output logic [CNT_W-1:0] cur_count,
  output logic             expire_evt,
  output logic             fire
);
  logic armed;

  assign expire_evt = tick && armed && (cur_count == '0) && !load;
  assign fire       = expire_evt && !mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_count <= '0;
      armed     <= 1'b0;
    end else if (load) begin
      cur_count <= load_val;
      armed     <= (load_val != '0);
    end else if (tick && armed) begin
      if (cur_count != '0)  cur_count <= cur_count - 1'b1;
      else if (periodic)    cur_count <= start_val;
      else                  armed     <= 1'b0;
    end
  end
endmodule

// File: rtl/lvt_countdown_timer.sv
module lvt_countdown_timer
  import lt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq_pulse,
  output logic [7:0]  irq_vector
);
  lt_entry_t          entry;
  logic [CNT_W-1:0]   start_val;
  logic [CNT_W-1:0]   cur_count;
  logic [SHIFT_W-1:0] shift;
  logic               load_evt;
  logic               tick;
  logic               expire_evt;
  logic               fire;

  lt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata,
    .cur_count, .reg_rdata, .entry, .start_val, .shift, .load_evt
  );

  lt_prescaler #(.SW(SHIFT_W)) u_pre (
    .clk, .rst_n, .clear(load_evt), .shift, .tick
  );

  lt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk, .rst_n, .load(load_evt), .load_val(reg_wdata[CNT_W-1:0]),
    .start_val, .tick, .periodic(entry.periodic), .mask(entry.mask),
    .cur_count, .expire_evt, .fire
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_pulse  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_pulse <= fire;
      if (fire) irq_vector <= entry.vector;
    end
  end
endmodule

// File: rtl/lt_checker.sv
module lt_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_pulse,
  input logic [7:0]       irq_vector,
  input logic             tick,
  input logic             mask,
  input logic             periodic,
  input logic [7:0]       vector,
  input logic             load_evt,
  input logic [CNT_W-1:0] load_val,
  input logic [CNT_W-1:0] start_val,
  input logic [CNT_W-1:0] cur_count
);
  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
  p_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(tick));
  p_mask_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> !$past(mask));
  p_vector_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (irq_vector == $past(vector)));
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse && $past(periodic)) |-> (cur_count == start_val));
  p_oneshot_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse && !$past(periodic)) |-> (cur_count == '0));
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (cur_count == $past(load_val)));
  p_zero_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(start_val == '0) && !$past(load_evt)) |-> !irq_pulse);
endmodule

bind lvt_countdown_timer lt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_pulse(irq_pulse), .irq_vector(irq_vector),
  .tick(tick), .mask(entry.mask), .periodic(entry.periodic),
  .vector(entry.vector), .load_evt(load_evt),
  .load_val(reg_wdata[CNT_W-1:0]), .start_val(start_val),
  .cur_count(cur_count)
);

// File: tb/lvt_countdown_timer_bench.sv
module lvt_countdown_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_pulse;
  logic [7:0]  irq_vector;

  int checks = 0;
  int errors = 0;
  longint cyc = 0;
  bit done = 1'b0;

  lvt_countdown_timer u_lvt_countdown_timer (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata,
    .reg_rdata, .irq_pulse, .irq_vector
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // divisor from the full 4-bit setting, computed as a lookup of divisors
  function automatic int divisor_of(input logic [3:0] cfg);
    case (cfg & 4'hB)
      4'hB: return 1;
      4'h0: return 2;   4'h1: return 4;   4'h2: return 8;   4'h3: return 16;
      4'h8: return 32;  4'h9: return 64;  4'hA: return 128;
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_fire(input longint k, input longint s, input int n,
                                  input bit per, input bit msk);
    longint t;
    if (msk || s == 0 || k <= 0 || (k % n) != 0) return 1'b0;
    t = k / n;
    if (per) return (t % (s + 1)) == 0;
    return t == s + 1;
  endfunction

  function automatic longint exp_count(input longint k, input longint s, input int n,
                                       input bit per);
    longint t;
    t = k / n;
    if (s == 0) return 0;
    if (per) return s - (t % (s + 1));
    return (t >= s) ? 0 : s - t;
  endfunction

  // Program entry and (optionally) divider, load start value, compare each cycle.
  task automatic run_case(input string tag, input bit per, input bit msk,
                          input logic [7:0] vec, input int s, input bit set_div,
                          input logic [3:0] dcfg, input int span);
    int n;
    int bad_p, bad_c, pulses, exp_pulses;
    longint load;
    n = set_div ? divisor_of(dcfg) : 1;
    if (set_div) wr(2'd3, {28'd0, dcfg});
    wr(2'd0, {14'd0, per, msk, 8'd0, vec});
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = s;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 2'd2;
    load = cyc;
    bad_p = 0; bad_c = 0; pulses = 0; exp_pulses = 0;
    for (int i = 0; i < span; i++) begin
      longint k;
      bit ef;
      #1;
      k = cyc - load;
      ef = exp_fire(k, s, n, per, msk);
      if (irq_pulse != ef) bad_p++;
      if (ef) begin
        exp_pulses++;
        if (irq_vector != vec) bad_p++;
      end
      if (irq_pulse) pulses++;
      if (reg_rdata != exp_count(k, s, n, per)) begin
        bad_c++;
        if (bad_c == 1)
          $display("  count at k=%0d: %0d vs %0d", k, reg_rdata, exp_count(k, s, n, per));
      end
      @(negedge clk);
    end
    check({tag, " pulse timing/vector R3 R4 R5 R6 R7"}, bad_p, 0);
    check({tag, " pulse total"}, pulses, exp_pulses);
    check({tag, " count trace R9"}, bad_c, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1 check("R1 irq idle", irq_pulse, 0);
    rd(2'd0, d); check("R1 entry", d, 32'h0001_0000);
    rd(2'd1, d); check("R1 start", d, 0);
    rd(2'd2, d); check("R1 count", d, 0);
    rd(2'd3, d); check("R1 divide", d, 0);
    // R2 reset divider is 1: one-shot S=3 without writing divide
    run_case("R2 reset-div", 1'b0, 1'b0, 8'h41, 3, 1'b0, 4'h0, 12);
    // R10 field keeping and read-only count
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); check("R10 entry fields", d, 32'h0003_00FF);
    wr(2'd3, 32'hFFFF_FFF4);
    rd(2'd3, d); check("R2 divide readback", d, 32'h0000_0000);
    wr(2'd3, 32'h0000_000F);
    rd(2'd3, d); check("R2 divide readback", d, 32'h0000_000B);
    wr(2'd0, 32'h0000_0000);
    wr(2'd1, 32'd50);
    wr(2'd2, 32'd7);
    rd(2'd2, d); check("R10 count write ignored", (d > 32'd40) && (d <= 32'd50), 1);
    // each divide setting, one-shot and periodic (R2 R3 R4)
    begin
      logic [3:0] codes [8] = '{4'hB, 4'h0, 4'h1, 4'h2, 4'h3, 4'h8, 4'h9, 4'hA};
      for (int c = 0; c < 8; c++) begin
        int n;
        n = divisor_of(codes[c]);
        run_case("R2 R3 oneshot", 1'b0, 1'b0, 8'(8'h10 + c), 2, 1'b1, codes[c], 3 * n + 2 * n + 4);
        run_case("R2 R4 periodic", 1'b1, 1'b0, 8'(8'h20 + c), 2, 1'b1, codes[c], 9 * n + 3);
      end
    end
    // R5 zero start value, both modes
    run_case("R5 zero oneshot", 1'b0, 1'b0, 8'h55, 0, 1'b1, 4'hB, 20);
    run_case("R5 zero periodic", 1'b1, 1'b0, 8'h56, 0, 1'b1, 4'hB, 20);
    // R6 masked, count keeps running
    run_case("R6 masked oneshot", 1'b0, 1'b1, 8'h66, 4, 1'b1, 4'h0, 30);
    run_case("R6 masked periodic", 1'b1, 1'b1, 8'h67, 3, 1'b1, 4'hB, 20);
    // R8 restart mid-run: a running count is reloaded by the next case
    run_case("R8 partial", 1'b1, 1'b0, 8'h80, 9, 1'b1, 4'h0, 7);
    run_case("R8 restart", 1'b1, 1'b0, 8'h81, 5, 1'b1, 4'h0, 30);
    // constrained random
    for (int r = 0; r < 12; r++) begin
      logic [3:0] cfg;
      int s, n, span;
      bit per, msk;
      cfg = 4'($urandom_range(0, 15));
      n = divisor_of(cfg);
      s = (n >= 32) ? $urandom_range(0, 6) : $urandom_range(0, 20);
      per = 1'($urandom_range(0, 1));
      msk = ($urandom_range(0, 5) == 0);
      span = 2 * (s + 1) * n + 6;
      run_case("R3 R4 random", per, msk, 8'($urandom_range(0, 255)), s, 1'b1, cfg, span);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule